// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a register bus and a small one-time-programmable fuse array of 128 words of 32 bits. The array is modelled behaviourally inside the block and starts blank (all zeros) after reset. Software reaches it through six word registers, selected by a 3-bit index:

| Index | Register |
|---|---|
| 0 | Control |
| 1 | Control clear alias |
| 2 | Timing |
| 3 | Sense trigger |
| 4 | Program data |
| 5 | Sense result |

Software first loads the timing register and then places a fuse address in the control register. Writing 1 to the trigger register senses the addressed word. Writing the program data register burns bits into the addressed word. That write is honoured only while the 16-bit unlock key 16'h3E77 sits in the top half of the control register.

Each operation is a timed sequence with three phases:
- a setup phase of RELAX+1 cycles;
- a strobe phase of STROBE+1 cycles, using the read or the program strobe length;
- a hold phase of RELAX+1 cycles.

The busy flag covers the whole sequence. A program can only set bits, never clear them. After a program completes, the unlock key erases itself, so every burn must be armed again. Misuse sets a sticky error flag, which software clears through the clear alias.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control, timing and sense-result registers read zero, and every fuse word is zero. Register indices are 0 control, 1 control-clear alias, 2 timing, 3 sense trigger, 4 program data and 5 sense result. Indices 1, 3 and 4 and any unused index read zero.
- R2: The control register holds the unlock key in bits 31:16, the error flag in bit 9, the busy flag in bit 8 and the fuse address in bits 6:0; all other bits read zero. A control write while idle loads the key and the address. Bits 8 and 9 of that write have no effect.
- R3: The timing register holds the program strobe length in bits 11:0, the relax length in bits 15:12 and the sense strobe length in bits 21:16. All other bits read zero.
- R4: Writing a value with bit 0 set to the sense trigger while idle starts a sense. Writing a value with bit 0 clear does nothing. Busy then stays high for exactly 2*(RELAX+1)+(STROBE_READ+1) cycles. When busy falls, the sense result register holds the addressed fuse word.
- R5: Writing the program data register while idle, with the key equal to 16'h3E77, starts a program sequence. Busy stays high for exactly 2*(RELAX+1)+(STROBE_PROG+1) cycles. The written value is ORed into the addressed word.
- R6: The key field returns to zero in the cycle busy falls after a program. A sense leaves the key unchanged.
- R7: Writing the program data register while idle with any other key sets the error flag. It starts nothing and leaves the array unchanged.
- R8: A sense trigger or a program data write while busy sets the error flag. It does not disturb the running operation.
- R9: The error flag stays set until a write to the clear alias has bit 9 set. A clear-alias write with bit 9 clear has no effect.
- R10: Control and timing writes while busy are ignored.
- R11: The fuse address is bank*8 + word, and all 128 addresses, including 127, are usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all timing counts use it |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Index of the register being written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Index of the register being read |
| rd_data | output | 32 | Read data, combinational from rd_sel |

## Verification
The hardest cases are collisions with a running sequence. Examples are a second trigger, a burn attempt, or a control or timing rewrite landing in the middle of an operation. These must be refused without disturbing the operation. The key must also clear on exactly the cycle busy drops. The stimulus sets nonzero relax and strobe lengths so each phase lasts several cycles. It then issues these writes at chosen offsets inside the setup, strobe and hold phases. After that it senses the same word again to show that only the intended bits were ORed in. A per-cycle reference model, advanced on every edge, compares every register read, so a one-cycle shift in busy or in key clearing shows up at once.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int ADDR_W = 7,
  parameter int SEL_W = 3,
  parameter logic [15:0] UNLOCK = 16'h3E77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SEL_W-1:0] SEL_CTRL = 0, SEL_CLR = 1, SEL_TIM = 2,
                               SEL_TRIG = 3, SEL_PDAT = 4, SEL_RES = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_STRB, ST_POST} st_t;

  st_t              state;
  logic [11:0]      cnt;
  logic [15:0]      key;
  logic             err;
  logic [ADDR_W-1:0] addr;
  logic [11:0]      t_prog;
  logic [3:0]       t_relax;
  logic [5:0]       t_read;
  logic             op_prog;
  logic [ADDR_W-1:0] op_addr;
  logic [31:0]      op_data;
  logic [3:0]       op_relax;
  logic [11:0]      op_strb;
  logic [31:0]      res_q;
  logic [31:0]      fuse [DEPTH];

  wire busy     = (state != ST_IDLE);
  wire key_ok   = (key == UNLOCK);
  wire wr_ctrl  = wr_en && wr_sel == SEL_CTRL;
  wire wr_clr   = wr_en && wr_sel == SEL_CLR;
  wire wr_tim   = wr_en && wr_sel == SEL_TIM;
  wire wr_trig  = wr_en && wr_sel == SEL_TRIG && wr_data[0];
  wire wr_pdat  = wr_en && wr_sel == SEL_PDAT;
  wire start_rd = wr_trig && !busy;
  wire start_pg = wr_pdat && !busy && key_ok;
  wire set_err  = (wr_trig && busy) || (wr_pdat && (busy || !key_ok));
  wire strb_end = (state == ST_STRB) && (cnt == 0);
  wire post_end = (state == ST_POST) && (cnt == 0);

  wire [31:0] ctrl_val = {key, 6'b0, err, busy, {(8-ADDR_W){1'b0}}, addr};
  wire [31:0] tim_val  = {10'b0, t_read, t_relax, t_prog};

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = ctrl_val;
      SEL_TIM:  rd_data = tim_val;
      SEL_RES:  rd_data = res_q;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key <= '0;
      addr <= '0;
      err <= 1'b0;
      t_prog <= '0;
      t_relax <= '0;
      t_read <= '0;
    end else begin
      if (wr_ctrl && !busy) begin
        key  <= wr_data[31:16];
        addr <= wr_data[ADDR_W-1:0];
      end else if (post_end && op_prog) begin
        key <= '0;
      end
      if (wr_tim && !busy) begin
        t_prog  <= wr_data[11:0];
        t_relax <= wr_data[15:12];
        t_read  <= wr_data[21:16];
      end
      if (set_err) err <= 1'b1;
      else if (wr_clr && wr_data[9]) err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt <= '0;
      op_prog <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      op_relax <= '0;
      op_strb <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_rd || start_pg) begin
          state    <= ST_PRE;
          cnt      <= {8'b0, t_relax};
          op_prog  <= start_pg;
          op_addr  <= addr;
          op_data  <= wr_data;
          op_relax <= t_relax;
          op_strb  <= start_pg ? t_prog : {6'b0, t_read};
        end
        ST_PRE: if (cnt == 0) begin
          state <= ST_STRB;
          cnt   <= op_strb;
        end else cnt <= cnt - 1'b1;
        ST_STRB: if (cnt == 0) begin
          state <= ST_POST;
          cnt   <= {8'b0, op_relax};
        end else cnt <= cnt - 1'b1;
        default: if (cnt == 0) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      for (int i = 0; i < DEPTH; i++) fuse[i] <= '0;
    end else if (strb_end) begin
      if (op_prog) fuse[op_addr] <= fuse[op_addr] | op_data;
      else res_q <= fuse[op_addr];
    end
  end

  // R5
  or_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_end && op_prog) |=> ((fuse[op_addr] & $past(fuse[op_addr])) == $past(fuse[op_addr])));

  // R6
  key_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op_prog) |-> (key == 16'h0));

  // R7
  nokey_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pdat && !busy && !key_ok) |=> (err && !busy));

  // R8
  collide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (wr_trig || wr_pdat)) |=> err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr_clr && wr_data[9])) |=> err);

  // R10
  tim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_tim) |=> $stable(tim_val));
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;

  otp_fuse_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                     .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data));

  always #5 clk = ~clk;

  int vecs = 0, bad = 0;
  string cur = "R1";

  int          m_left = 0;
  logic [3:0]  m_r = 0;
  logic [11:0] m_s = 0;
  bit          m_prog = 0;
  logic [6:0]  m_oa = 0;
  logic [31:0] m_od = 0;
  logic [31:0] m_arr [128];
  logic [31:0] m_res = 0;
  logic [15:0] m_key = 0;
  bit          m_err = 0;
  logic [6:0]  m_addr = 0;
  logic [11:0] m_tp = 0;
  logic [3:0]  m_tr = 0;
  logic [5:0]  m_ts = 0;

  function automatic logic [31:0] expect_rd(input logic [2:0] s);
    case (s)
      3'd0: return {m_key, 6'b0, m_err, (m_left > 0), 1'b0, m_addr};
      3'd2: return {10'b0, m_ts, m_tr, m_tp};
      3'd5: return m_res;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model(input bit we, input logic [2:0] s, input logic [31:0] d);
    bit bz;
    bz = (m_left > 0);
    if (bz) begin
      m_left--;
      if (m_left == m_r + 1) begin
        if (m_prog) m_arr[m_oa] = m_arr[m_oa] | m_od;
        else m_res = m_arr[m_oa];
      end
      if (m_left == 0 && m_prog) m_key = 0;
    end
    if (we) begin
      case (s)
        3'd0: if (!bz) begin m_key = d[31:16]; m_addr = d[6:0]; end
        3'd1: if (d[9]) m_err = 0;
        3'd2: if (!bz) begin m_tp = d[11:0]; m_tr = d[15:12]; m_ts = d[21:16]; end
        3'd3: if (d[0]) begin
          if (bz) m_err = 1;
          else begin
            m_prog = 0; m_r = m_tr; m_s = {6'b0, m_ts}; m_oa = m_addr;
            m_left = 2*(m_r+1) + m_s + 1;
          end
        end
        3'd4: if (bz || m_key != 16'h3E77) m_err = 1;
          else begin
            m_prog = 1; m_r = m_tr; m_s = m_tp; m_oa = m_addr; m_od = d;
            m_left = 2*(m_r+1) + m_s + 1;
          end
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit we, input logic [2:0] s, input logic [31:0] d, input logic [2:0] rs);
    wr_en = we; wr_sel = s; wr_data = d; rd_sel = rs;
    @(posedge clk);
    model(we, s, d);
    @(negedge clk);
    vecs++;
    if (rd_data !== expect_rd(rs)) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", cur, rs, rd_data, expect_rd(rs));
    end
  endtask

  task automatic idle(input int n, input logic [2:0] rs);
    for (int i = 0; i < n; i++) step(0, 0, 0, rs);
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && m_left > 0; i++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic sense(input logic [6:0] a);
    step(1, 0, {m_key, 9'b0, a}, 0);
    step(1, 3, 1, 0);
    drain();
    step(0, 0, 0, 5);
  endtask

  task automatic burn(input logic [6:0] a, input logic [31:0] v);
    step(1, 0, {16'h3E77, 9'b0, a}, 0);
    step(1, 4, v, 0);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_arr[i] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cur = "R1";
    idle(1, 0); idle(1, 2); idle(1, 5); idle(1, 1); idle(1, 3); idle(1, 4); idle(1, 7);
    sense(7'd127);
    cur = "R3";
    step(1, 2, 32'hFFC0_0000 | (32'd2 << 16) | (32'd1 << 12) | 32'd3, 2);
    idle(1, 2);
    cur = "R2";
    step(1, 0, {16'h1234, 6'h3F, 1'b1, 1'b1, 1'b1, 7'd21}, 0);
    idle(1, 0);
    cur = "R4";
    step(1, 3, 32'hFFFF_FFFE, 0);
    idle(2, 0);
    sense(7'd21);
    cur = "R11";
    burn({4'd2, 3'd5}, 32'hA5A5_0001);
    sense(7'd21);
    cur = "R5";
    burn(7'd21, 32'h0000_F00F);
    sense(7'd21);
    burn(7'd21, 32'h0);
    sense(7'd21);
    cur = "R6";
    step(1, 0, {16'h3E77, 9'b0, 7'd9}, 0);
    step(1, 3, 1, 0);
    drain();
    step(1, 4, 32'h8000_0000, 0);
    drain();
    step(1, 4, 32'h1, 0);
    idle(1, 0);
    sense(7'd9);
    cur = "R9";
    step(1, 1, 32'hFFFF_FDFF, 0);
    idle(1, 0);
    step(1, 1, 32'h200, 0);
    idle(1, 0);
    cur = "R7";
    step(1, 0, {16'h3E76, 9'b0, 7'd40}, 0);
    step(1, 4, 32'hFFFF_FFFF, 0);
    idle(2, 0);
    sense(7'd40);
    step(1, 1, 32'h200, 0);
    cur = "R8";
    step(1, 0, {16'h3E77, 9'b0, 7'd21}, 0);
    step(1, 3, 1, 0);
    step(1, 3, 1, 0);
    step(1, 4, 32'hFFFF_FFFF, 0);
    idle(3, 0);
    step(1, 1, 32'h200, 0);
    step(1, 4, 32'hFFFF_FFFF, 0);
    drain();
    step(0, 0, 0, 5);
    cur = "R10";
    step(1, 3, 1, 0);
    step(1, 0, {16'h3E77, 9'b0, 7'd50}, 0);
    step(1, 2, 32'h0, 2);
    idle(4, 0);
    step(1, 2, 32'h0, 2);
    drain();
    step(0, 0, 0, 2);
    step(0, 0, 0, 5);
    cur = "R3";
    step(1, 2, 32'h0, 2);
    burn(7'd127, 32'h0F0F_0F0F);
    sense(7'd127);
    step(1, 2, (32'd5 << 16) | (32'd15 << 12) | 32'd20, 2);
    cur = "R5";
    burn(7'd0, 32'hDEAD_BEEF);
    sense(7'd0);
    sense(7'd127);
    idle(3, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule